// File: doc/BRIEF.md
# Three-channel ring timer unit

The unit holds three identical 16-bit timer channels. Each channel has a counter and a reload register. A per-channel mode byte picks one of four behaviours: periodic down-counting from one of four prescaled clock enables, counting events, measuring pulse period or width, and a single-shot countdown that ends in a converter-start pulse. Software reaches the unit through one byte-wide write port. It selects a channel and one of four registers: the mode byte, the low reload byte, the high reload byte, or the start register that all channels share. It reads the counters from a flat readback bus.

In event mode a channel counts edges of its own external pin, with a selectable polarity, or the underflow strobes of its ring neighbour. Channel 0 listens to channel 2, channel 1 to channel 0, and channel 2 to channel 1. Two channels can therefore be cascaded into a longer count. In measurement mode the counter counts up. On each selected pin edge it places its count in the readback register and restarts. If the counter runs past its top value, a sticky flag is set.

Top module: `ring_timer_unit`

## Requirements
- R1: After reset every counter reads 0, and `irqOut`, `adcStart` and `ovfFlag` are all 0.
- R2: Write-port register codes are: 0 = mode byte, 1 = low reload byte, 2 = high reload byte, and 3 = start register (bit i starts channel i, and `wrChan` is ignored). A reload-byte write to a stopped channel that is not in measurement mode also loads the counter, so the readback shows the new 16-bit reload value on the cycle after the write.
- R3: The mode byte has these fields: [1:0] mode (00 timer or trigger, 01 event, 10 measure, 11 reserved), [2] variant, [3] alternate source or both edges, and [5:4] clock-enable select. In timer mode (mode 00, bit 2 = 0), a started channel counts down by one on each cycle in which `clkEn[sel]` is high, and other enables are ignored. A tick at 0 reloads the counter from the reload register and gives a one-cycle `irqOut` pulse, so a reload value N gives one pulse every N+1 ticks.
- R4: A reload write to a running channel changes only the reload register. The counter keeps counting, and the new value is used at the next underflow. If the write lands in the same cycle as an underflow, the old value is reloaded.
- R5: Clearing a channel's start bit stops it. Its counter holds its value, and it gives no `irqOut` pulse whatever the clock enables do.
- R6: In event mode with bit 3 = 0, the counter counts synchronised `extIn[i]` edges and ignores the clock enables. Bit 2 = 0 counts rising edges and bit 2 = 1 counts falling edges. Underflow and reload work as in R3.
- R7: In event mode with bit 3 = 1, the counter counts the `irqOut` pulses of its ring neighbour (0 from 2, 1 from 0, 2 from 1) and no other channel's pulses.
- R8: In trigger mode (mode 00, bit 2 = 1), a 0-to-1 write of the start bit loads the counter from the reload register. The counter then counts selected ticks down. The tick that finds it at 0 gives one-cycle `adcStart` and `irqOut` pulses, and the counter then stays at 0 without restarting. With reload N the pulse comes N+1 ticks after the trigger.
- R9: In measurement mode (mode 10), the counter counts up on selected ticks. On a selected edge of `extIn[i]` (bits [3:2]: 00 rising to rising, 01 falling to falling, 1x every edge, which measures width), the readback shows the number of ticks since the previous selected edge, the counter restarts and `irqOut` pulses. The readback holds the last result until the next selected edge.
- R10: In measurement mode, a tick with the counter at FFFFh sets `ovfFlag[i]`. The flag stays set until the channel's mode byte is written, and that write clears it.
- R11: With mode 11 the counter of a started channel holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrChan | input | 2 | Channel addressed by the write |
| wrReg | input | 2 | Register code (0 mode, 1 reload low, 2 reload high, 3 start) |
| wrData | input | 8 | Write data |
| clkEn | input | 4 | Prescaled clock enables, selected by mode bits [5:4] |
| extIn | input | 3 | Asynchronous external pulse input per channel |
| cntOut | output | 48 | Readback, channel i in bits [16i+15:16i] |
| ovfFlag | output | 3 | Sticky measurement overflow per channel |
| irqOut | output | 3 | Underflow, capture or trigger-done strobe per channel |
| adcStart | output | 3 | Converter start pulse per channel |

## Verification
Two functions can fall in the same cycle: a software reload write and an underflow that reloads the counter. In a run of random tick patterns, the bench writes new low reload bytes to a running channel at fixed intervals, so some writes coincide with the zero-count tick. A bench model reloads the old value in that case and keeps the new one for the next underflow. It compares its count and strobe with the readback on every cycle.

// File: rtl/rtu_pkg.sv
package rtu_pkg;
  localparam int CLK_SEL_W = 2;
  localparam int NUM_CLK   = 1 << CLK_SEL_W;
  localparam int MODE_W    = 4 + CLK_SEL_W;

  typedef enum logic [1:0] {
    MD_TIMER = 2'b00,
    MD_EVENT = 2'b01,
    MD_PULSE = 2'b10,
    MD_RSVD  = 2'b11
  } rtuMode_e;

  typedef struct packed {
    logic down;
    logic up;
    logic reloadCnt;
    logic capture;
    logic tickNow;
    logic setOvf;
    logic clrOvf;
    logic wrLo;
    logic wrHi;
    logic loadCnt;
    logic showCap;
  } rtuStrobe_t;
endpackage

// File: rtl/rtu_ctrl.sv
module rtu_ctrl
  import rtu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrMode,
  input  logic              wrLo,
  input  logic              wrHi,
  input  logic              wrStart,
  input  logic              startVal,
  input  logic [MODE_W-1:0] modeIn,
  input  logic [NUM_CLK-1:0] clkEn,
  input  logic              extIn,
  input  logic              nbrUf,
  input  logic              cntZero,
  input  logic              cntMax,
  output rtuStrobe_t        strb,
  output logic              irq,
  output logic              adc
);
  logic [MODE_W-1:0] modeReg;
  logic startBit, busy, pinPrev;
  logic [SYNC_STAGES-1:0] syncQ;

  rtuMode_e mode;
  logic variantBit, altBit;
  logic [CLK_SEL_W-1:0] clkSel;
  logic tickNow, pinNow, riseEdge, fallEdge, measEdge, evtSrc;
  logic isTimer, isTrig, isEvt, isPulse;
  logic running, countEvt, underflow, trigDone, startRise;

  assign mode       = rtuMode_e'(modeReg[1:0]);
  assign variantBit = modeReg[2];
  assign altBit     = modeReg[3];
  assign clkSel     = modeReg[MODE_W-1 -: CLK_SEL_W];

  always_comb begin
    tickNow  = clkEn[clkSel];
    pinNow   = syncQ[SYNC_STAGES-1];
    riseEdge = pinNow & ~pinPrev;
    fallEdge = ~pinNow & pinPrev;
    measEdge = altBit ? (riseEdge | fallEdge) : (variantBit ? fallEdge : riseEdge);
    evtSrc   = altBit ? nbrUf : (variantBit ? fallEdge : riseEdge);

    isTimer  = (mode == MD_TIMER) && !variantBit;
    isTrig   = (mode == MD_TIMER) && variantBit;
    isEvt    = (mode == MD_EVENT);
    isPulse  = (mode == MD_PULSE);

    running   = startBit && (!isTrig || busy);
    countEvt  = isEvt ? evtSrc : tickNow;
    underflow = running && (isTimer || isEvt) && countEvt && cntZero;
    trigDone  = running && isTrig && countEvt && cntZero;
    startRise = wrStart && startVal && !startBit;

    strb.down      = running && (isTimer || isEvt || isTrig) && countEvt && !cntZero;
    strb.reloadCnt = underflow || (startRise && isTrig);
    strb.capture   = running && isPulse && measEdge;
    strb.tickNow   = tickNow;
    strb.up        = running && isPulse && tickNow && !measEdge;
    strb.setOvf    = running && isPulse && tickNow && !measEdge && cntMax;
    strb.clrOvf    = wrMode;
    strb.wrLo      = wrLo;
    strb.wrHi      = wrHi;
    strb.loadCnt   = !running && !isPulse && (wrLo || wrHi);
    strb.showCap   = isPulse;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= '0;
      startBit <= 1'b0;
      busy     <= 1'b0;
      syncQ    <= '0;
      pinPrev  <= 1'b0;
      irq      <= 1'b0;
      adc      <= 1'b0;
    end else begin
      if (wrMode) modeReg <= modeIn;
      if (wrStart) startBit <= startVal;
      if (wrStart && !startVal)    busy <= 1'b0;
      else if (startRise && isTrig) busy <= 1'b1;
      else if (trigDone)           busy <= 1'b0;
      syncQ   <= {syncQ[SYNC_STAGES-2:0], extIn};
      pinPrev <= pinNow;
      irq     <= underflow || trigDone || strb.capture;
      adc     <= trigDone;
    end
  end
endmodule

// File: rtl/rtu_datapath.sv
module rtu_datapath
  import rtu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  rtuStrobe_t         strb,
  input  logic [CNT_W/2-1:0] wrByte,
  output logic [CNT_W-1:0]   readback,
  output logic               cntZero,
  output logic               cntMax,
  output logic               ovf
);
  localparam int HALF_W = CNT_W / 2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt, rel, nextRel, tickAdd;

  always_comb begin
    nextRel = rel;
    if (strb.wrLo) nextRel[HALF_W-1:0] = wrByte;
    if (strb.wrHi) nextRel[CNT_W-1:HALF_W] = wrByte;
    tickAdd = strb.tickNow ? ONE : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      rel <= '0;
      ovf <= 1'b0;
    end else begin
      if (strb.capture) begin
        rel <= cnt + tickAdd;
        cnt <= '0;
      end else begin
        rel <= nextRel;
        if (strb.loadCnt)        cnt <= nextRel;
        else if (strb.reloadCnt) cnt <= rel;
        else if (strb.down)      cnt <= cnt - ONE;
        else if (strb.up)        cnt <= cnt + ONE;
      end
      if (strb.clrOvf)      ovf <= 1'b0;
      else if (strb.setOvf) ovf <= 1'b1;
    end
  end

  assign readback = strb.showCap ? rel : cnt;
  assign cntZero  = (cnt == '0);
  assign cntMax   = &cnt;
endmodule

// File: rtl/rtu_channel.sv
module rtu_channel
  import rtu_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrMode,
  input  logic               wrLo,
  input  logic               wrHi,
  input  logic               wrStart,
  input  logic               startVal,
  input  logic [CNT_W/2-1:0] wrByte,
  input  logic [NUM_CLK-1:0] clkEn,
  input  logic               extIn,
  input  logic               nbrUf,
  output logic [CNT_W-1:0]   readback,
  output logic               irq,
  output logic               adc,
  output logic               ovf
);
  rtuStrobe_t strb;
  logic cntZero, cntMax;

  rtu_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrMode(wrMode), .wrLo(wrLo), .wrHi(wrHi),
    .wrStart(wrStart), .startVal(startVal), .modeIn(wrByte[MODE_W-1:0]),
    .clkEn(clkEn), .extIn(extIn), .nbrUf(nbrUf), .cntZero(cntZero),
    .cntMax(cntMax), .strb(strb), .irq(irq), .adc(adc)
  );

  rtu_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrByte(wrByte),
    .readback(readback), .cntZero(cntZero), .cntMax(cntMax), .ovf(ovf)
  );
endmodule

// File: rtl/ring_timer_unit.sv
module ring_timer_unit
  import rtu_pkg::*;
#(
  parameter int NUM_TMR     = 3,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [$clog2(NUM_TMR)-1:0] wrChan,
  input  logic [1:0]                 wrReg,
  input  logic [CNT_W/2-1:0]         wrData,
  input  logic [NUM_CLK-1:0]         clkEn,
  input  logic [NUM_TMR-1:0]         extIn,
  output logic [NUM_TMR*CNT_W-1:0]   cntOut,
  output logic [NUM_TMR-1:0]         ovfFlag,
  output logic [NUM_TMR-1:0]         irqOut,
  output logic [NUM_TMR-1:0]         adcStart
);
  localparam int CH_W = $clog2(NUM_TMR);

  logic wrStart;
  assign wrStart = wrEn && (wrReg == 2'd3);

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_ch
    localparam int NBR = (i + NUM_TMR - 1) % NUM_TMR;
    logic hit;
    assign hit = wrEn && (wrChan == CH_W'(i));

    rtu_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) ch_i (
      .clk(clk), .rstN(rstN),
      .wrMode(hit && (wrReg == 2'd0)),
      .wrLo(hit && (wrReg == 2'd1)),
      .wrHi(hit && (wrReg == 2'd2)),
      .wrStart(wrStart), .startVal(wrData[i]), .wrByte(wrData),
      .clkEn(clkEn), .extIn(extIn[i]), .nbrUf(irqOut[NBR]),
      .readback(cntOut[i*CNT_W +: CNT_W]), .irq(irqOut[i]),
      .adc(adcStart[i]), .ovf(ovfFlag[i])
    );
  end
endmodule

// File: rtl/rtu_checker.sv
module rtu_checker #(
  parameter int NUM_TMR = 3,
  parameter int CNT_W   = 16,
  parameter int CH_W    = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     wrEn,
  input logic [CH_W-1:0]          wrChan,
  input logic [1:0]               wrReg,
  input logic [NUM_TMR*CNT_W-1:0] cntOut,
  input logic [NUM_TMR-1:0]       ovfFlag,
  input logic [NUM_TMR-1:0]       irqOut,
  input logic [NUM_TMR-1:0]       adcStart
);
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    logic modeWr;
    assign modeWr = wrEn && (wrReg == 2'd0) && (wrChan == CH_W'(i));

    p_adc_once_r8: assert property (@(posedge clk) disable iff (!rstN)
      adcStart[i] |=> !adcStart[i]);
    p_adc_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
      adcStart[i] |-> irqOut[i]);
    p_adc_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
      adcStart[i] |-> (cntOut[i*CNT_W +: CNT_W] == '0));
    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
      (ovfFlag[i] && !modeWr) |=> ovfFlag[i]);
    p_ovf_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
      modeWr |=> !ovfFlag[i]);
  end
endmodule

bind ring_timer_unit rtu_checker #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W), .CH_W(CH_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrChan(wrChan), .wrReg(wrReg),
  .cntOut(cntOut), .ovfFlag(ovfFlag), .irqOut(irqOut), .adcStart(adcStart)
);

// File: tb/ring_timer_unit_tb_top.sv
module ring_timer_unit_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [1:0] wrChan = '0, wrReg = '0;
  logic [7:0] wrData = '0;
  logic [3:0] clkEn = '0;
  logic [2:0] extIn = '0;
  logic [47:0] cntOut;
  logic [2:0] ovfFlag, irqOut, adcStart;

  int nChk = 0, nFail = 0;

  ring_timer_unit dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrChan(wrChan), .wrReg(wrReg),
    .wrData(wrData), .clkEn(clkEn), .extIn(extIn), .cntOut(cntOut),
    .ovfFlag(ovfFlag), .irqOut(irqOut), .adcStart(adcStart)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int cntOf(int ch);
    return int'(cntOut[ch*16 +: 16]);
  endfunction

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] ch, logic [1:0] rg, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrChan = ch; wrReg = rg; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    #(CLK_P*190000);
    nChk++; nFail++;
    $display("FAIL R1 watchdog actual hung expected finished");
    finishRun();
  end

  initial begin
    int mCnt, mRel, mIrq, cnt, pulses, at;
    void'($urandom(32'h5eed));
    idle(3);
    chk("R1 count in reset", int'(cntOut != 0), 0);
    rstN = 1'b1;
    idle(1);
    chk("R1 count after reset", int'(cntOut != 0), 0);
    chk("R1 strobes after reset", int'({irqOut, adcStart, ovfFlag}), 0);

    // R2: reload bytes load a stopped counter
    wr(0, 0, 8'h20);
    wr(0, 1, 8'h34);
    chk("R2 low byte load", cntOf(0), 16'h0034);
    wr(0, 2, 8'h12);
    chk("R2 high byte load", cntOf(0), 16'h1234);
    wr(0, 2, 8'h00);
    wr(0, 1, 8'h03);
    chk("R2 reload 3", cntOf(0), 3);

    // R3 / R4: random ticks on select 2 with reload writes while running
    mCnt = 3; mRel = 3; mIrq = 0;
    wr(0, 3, 8'h01);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      chk("R3 random count", cntOf(0), mCnt);
      chk("R3 random strobe", int'(irqOut[0]), mIrq);
      clkEn = 4'($urandom);
      wrEn = 1'b0;
      mIrq = 0;
      if (clkEn[2]) begin
        if (mCnt == 0) begin mCnt = mRel; mIrq = 1; end
        else mCnt = mCnt - 1;
      end
      if (i % 23 == 11) begin
        wrEn = 1'b1; wrChan = 2'd0; wrReg = 2'd1; wrData = 8'($urandom % 6);
        mRel = (mRel & 16'hFF00) | int'(wrData);   // R4 takes effect later
      end
    end
    @(negedge clk);
    chk("R4 final count", cntOf(0), mCnt);
    wrEn = 1'b0; clkEn = '0;

    // R5: stop holds
    wr(0, 3, 8'h00);
    cnt = cntOf(0); pulses = 0;
    clkEn = 4'hF;
    repeat (10) begin @(negedge clk); if (irqOut[0]) pulses++; end
    chk("R5 held count", cntOf(0), cnt);
    chk("R5 no strobe", pulses, 0);
    clkEn = '0;

    // R6: external edge events on channel 1
    wr(1, 0, 8'h01); wr(1, 1, 8'd3); wr(1, 2, 8'h00);
    chk("R2 channel 1 load", cntOf(1), 3);
    wr(0, 3, 8'h02);
    clkEn = 4'hF; idle(5);
    chk("R6 clocks ignored", cntOf(1), 3);
    extIn[1] = 1'b1; idle(5);
    chk("R6 rising counted", cntOf(1), 2);
    extIn[1] = 1'b0; idle(5);
    chk("R6 falling ignored", cntOf(1), 2);
    extIn[1] = 1'b1; idle(5);
    chk("R6 second rising", cntOf(1), 1);
    wr(1, 0, 8'h05);
    extIn[1] = 1'b0; idle(5);
    chk("R6 falling polarity", cntOf(1), 0);
    extIn[1] = 1'b1; idle(5);
    chk("R6 rising ignored", cntOf(1), 0);
    extIn[1] = 1'b0; idle(5);
    chk("R6 underflow reload", cntOf(1), 3);
    clkEn = '0;

    // R7: cascade ring
    wr(0, 3, 8'h00);
    wr(0, 0, 8'h00); wr(0, 1, 8'd1); wr(0, 2, 8'h00);
    wr(1, 0, 8'h09); wr(1, 1, 8'd100); wr(1, 2, 8'h00);
    wr(2, 0, 8'h09); wr(2, 1, 8'd50); wr(2, 2, 8'h00);
    wr(0, 3, 8'h07);
    clkEn = 4'h1; pulses = 0;
    repeat (30) begin @(negedge clk); if (irqOut[0]) pulses++; end
    clkEn = '0;
    repeat (4) begin @(negedge clk); if (irqOut[0]) pulses++; end
    chk("R3 underflow pulses reload 1", pulses, 15);
    chk("R7 neighbour counted", cntOf(1), 100 - pulses);
    chk("R7 non-neighbour ignored", cntOf(2), 50);

    // R8: single-shot trigger on channel 2
    wr(0, 3, 8'h00);
    wr(2, 0, 8'h04); wr(2, 1, 8'd3); wr(2, 2, 8'h00);
    chk("R8 preload", cntOf(2), 3);
    clkEn = 4'h1;
    @(negedge clk);
    wrEn = 1'b1; wrReg = 2'd3; wrData = 8'h04;
    pulses = 0; at = 0;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      wrEn = 1'b0;
      if (adcStart[2]) begin pulses++; at = i; end
    end
    chk("R8 single start pulse", pulses, 1);
    chk("R8 pulse timing", at, 5);
    chk("R8 stays at zero", cntOf(2), 0);
    clkEn = '0;

    // R11: reserved mode holds
    wr(0, 3, 8'h00);
    wr(1, 0, 8'h03); wr(1, 1, 8'd9); wr(1, 2, 8'h00);
    wr(0, 3, 8'h02);
    clkEn = 4'hF;
    extIn[1] = 1'b1; idle(5); extIn[1] = 1'b0; idle(5);
    chk("R11 reserved hold", cntOf(1), 9);
    clkEn = '0;

    // R9: period then width measurement on channel 0
    wr(0, 3, 8'h00);
    extIn = '0;
    wr(0, 0, 8'h02);
    wr(0, 3, 8'h01);
    clkEn = 4'h1; idle(3);
    pulses = 0;
    extIn[0] = 1'b1;
    repeat (10) begin @(negedge clk); if (irqOut[0]) pulses++; end
    extIn[0] = 1'b0;
    repeat (10) begin @(negedge clk); if (irqOut[0]) pulses++; end
    extIn[0] = 1'b1;
    repeat (6) begin @(negedge clk); if (irqOut[0]) pulses++; end
    chk("R9 period ticks", cntOf(0), 20);
    chk("R9 capture strobes", pulses, 2);
    wr(0, 0, 8'h0A);
    extIn[0] = 1'b0; idle(10);
    extIn[0] = 1'b1; idle(7);
    extIn[0] = 1'b0; idle(6);
    chk("R9 width ticks", cntOf(0), 7);

    // R10: overflow sticky and cleared by mode write
    chk("R10 no overflow yet", int'(ovfFlag[0]), 0);
    idle(65600);
    chk("R10 overflow set", int'(ovfFlag[0]), 1);
    chk("R9 capture held", cntOf(0), 7);
    idle(10);
    chk("R10 overflow sticky", int'(ovfFlag[0]), 1);
    wr(0, 0, 8'h0A);
    chk("R10 overflow cleared", int'(ovfFlag[0]), 0);
    clkEn = '0;
    idle(2);
    finishRun();
  end
endmodule